// File: doc/BRIEF.md
# PCM Timeslot to UART Bridge

This block sits on a telephone codec's PCM bus and runs entirely from the bus's free-running 2.048 MHz bit clock. It generates the 8 kHz frame strobe and a single-slot enable. In that slot it shifts in the 8-bit speech sample the codec drives. It then replays that sample toward a host processor as an asynchronous serial character. The serial bit timing is derived directly from the PCM clock, so no second oscillator is needed.

Each 256-clock frame carries exactly one character. The character is a low start bit and eight data bits, each 18 clocks long, giving roughly 113.8 kbaud. A standard 115200-baud receiver accepts this rate. The line then rests high for the remaining 94 clocks, which the receiver treats as a long stop period.

The host chooses with one select level whether its serial receive pin sees this speech stream or a debug console input. After reset the console is selected. When no console is fitted, the console input is pulled low and the host sees a steady break.

Top module: `pcm_uart_bridge`

## Requirements
- R1: `fsync` is high for exactly one clock in every 256, and the frame counter restarts after each pulse.
- R2: `slot_en` is high for the 8 clocks that directly follow the `fsync` clock and is never high together with `fsync`.
- R3: During the slot, `pcm_rx` is sampled on each rising clock edge. The first bit sampled is the sample's most significant bit.
- R4: With the stream selected, each captured sample appears on `host_rx` as a low start bit followed by the 8 data bits, least significant bit first. Each bit lasts 18 clocks. The start bit begins 9 clocks after the `fsync` clock, which is the clock after the slot closes.
- R5: After the eighth data bit, the stream stays high until the next start bit. This gives one character per frame and 94 idle clocks.
- R6: With `sel_voice` low, `host_rx` equals `con_rx` and the codec data has no effect. With `sel_voice` high, `host_rx` carries the stream and `con_rx` has no effect. Reset selects the console, so a low `con_rx` holds `host_rx` low.
- R7: A change of `sel_voice` takes effect only while no character is in progress. A character that has started is completed on the path it started on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz PCM bit clock |
| rst_n | input | 1 | Active-low reset |
| pcm_rx | input | 1 | Serial sample data from the codec |
| con_rx | input | 1 | Debug console serial input |
| sel_voice | input | 1 | High selects the speech stream, low selects the console |
| fsync | output | 1 | One-clock frame strobe, once per 256 clocks |
| slot_en | output | 1 | High during the 8-clock sample slot |
| host_rx | output | 1 | Serial receive line toward the host |

## Verification
The stream is driven with all-zero and all-one samples, which separate the start and stop levels from the data. Alternating patterns such as 0xA5 and 0x5A, and single-bit values such as 0x01 and 0x80, expose a reversed bit order or a one-bit slip in either the capture or the transmit shift, along with a run of computed values. In console mode the console input is toggled while the codec drives data, to show that only the console reaches the host. The select is also flipped in the middle of a character in both directions. A zero sample keeps the stream low while the console sits high, so any early switch shows up as a wrong level.

// File: rtl/pcm_uart_bridge.sv
module pcm_uart_bridge #(
  parameter int FRAME_CLKS  = 256,
  parameter int SAMPLE_BITS = 8,
  parameter int BIT_CLKS    = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pcm_rx,
  input  logic con_rx,
  input  logic sel_voice,
  output logic fsync,
  output logic slot_en,
  output logic host_rx
);
  localparam int FW = $clog2(FRAME_CLKS);
  localparam int BW = $clog2(BIT_CLKS);
  localparam int IW = $clog2(SAMPLE_BITS + 1);

  logic [FW-1:0]          fcnt;
  logic [SAMPLE_BITS-2:0] shreg;
  logic [SAMPLE_BITS-1:0] sample;
  logic                   active;
  logic [BW-1:0]          btmr;
  logic [IW-1:0]          bidx;
  logic                   sel_q;

  assign fsync   = (fcnt == FW'(FRAME_CLKS - 1));
  assign slot_en = (fcnt < FW'(SAMPLE_BITS));

  wire                   last_slot = (fcnt == FW'(SAMPLE_BITS - 1));
  wire [SAMPLE_BITS-1:0] word      = {shreg, pcm_rx};
  wire [IW-1:0]          dsel      = bidx - 1'b1;
  wire [SAMPLE_BITS-1:0] shifted   = sample >> dsel;
  wire                   line      = !active || ((bidx != '0) && shifted[0]);

  assign host_rx = sel_q ? line : con_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt   <= '0;
      shreg  <= '0;
      sample <= '1;
      active <= 1'b0;
      btmr   <= '0;
      bidx   <= '0;
      sel_q  <= 1'b0;
    end else begin
      fcnt <= fsync ? '0 : fcnt + 1'b1;
      if (slot_en) shreg <= word[SAMPLE_BITS-2:0];
      if (!active) sel_q <= sel_voice;
      if (last_slot) begin
        sample <= word;
        active <= 1'b1;
        btmr   <= '0;
        bidx   <= '0;
      end else if (active) begin
        if (btmr == BW'(BIT_CLKS - 1)) begin
          btmr <= '0;
          if (bidx == IW'(SAMPLE_BITS)) active <= 1'b0;
          else                          bidx   <= bidx + 1'b1;
        end else begin
          btmr <= btmr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_uart_bridge_chk.sv
module pcm_uart_bridge_chk #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          con_rx,
  input logic          fsync,
  input logic          slot_en,
  input logic          host_rx,
  input logic          active,
  input logic          sel_q,
  input logic [IW-1:0] bidx
);
  assert_fsync_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> !fsync);

  assert_slot_after_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_en) |-> $past(fsync));

  assert_slot_not_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |-> !slot_en);

  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && active && bidx == '0) |-> !host_rx);

  assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !active) |-> host_rx);

  assert_console_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> (host_rx == con_rx));

  assert_switch_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> !$past(active));
endmodule

bind pcm_uart_bridge pcm_uart_bridge_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .con_rx(con_rx), .fsync(fsync), .slot_en(slot_en),
  .host_rx(host_rx), .active(active), .sel_q(sel_q), .bidx(bidx)
);

// File: tb/pcm_uart_bridge_tb.sv
module pcm_uart_bridge_tb;
  logic clk = 1'b0, rst_n = 1'b0, pcm_rx = 1'b0, con_rx = 1'b0, sel_voice = 1'b0;
  logic fsync, slot_en, host_rx;

  pcm_uart_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .pcm_rx(pcm_rx), .con_rx(con_rx),
    .sel_voice(sel_voice), .fsync(fsync), .slot_en(slot_en), .host_rx(host_rx)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] expq[$];
  logic mon_en = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // monitor: decodes the stream and compares against the queue
  int since = 0, st = 0, k = 0;
  logic [7:0] got;
  always @(negedge clk) begin
    since = fsync ? 0 : since + 1;
    if (!mon_en) st = 0;
    else if (st == 0) begin
      if (!host_rx) begin
        chk(since == 9, "R4 start offset", since, 9);
        st = 1; k = 0;
      end
    end else begin
      k++;
      if (k == 9) chk(host_rx == 1'b0, "R4 start bit level", int'(host_rx), 0);
      for (int j = 1; j <= 8; j++)
        if (k == 18*j + 9) got[j-1] = host_rx;
      if (k == 171) begin
        chk(host_rx == 1'b1, "R5 idle after char", int'(host_rx), 1);
        if (expq.size() == 0) chk(1'b0, "R5 unexpected char", int'(got), -1);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(got == e, "R3 R4 char data", int'(got), int'(e));
        end
        st = 0;
      end
    end
  end

  task automatic drive_frame(input logic [7:0] b, input bit expect_it);
    do @(negedge clk); while (!fsync);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      pcm_rx = b[i];
    end
    if (expect_it) expq.push_back(b);
  endtask

  initial begin
    #(4*200000);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int n, bad;
    repeat (5) @(negedge clk);
    chk(host_rx == 1'b0, "R6 reset break", int'(host_rx), 0);
    chk(fsync == 1'b0, "R1 reset fsync", int'(fsync), 0);
    rst_n = 1'b1;

    // R1 period
    do @(negedge clk); while (!fsync);
    n = 0;
    do begin @(negedge clk); n++; end while (!fsync);
    chk(n == 256, "R1 frame period", n, 256);
    bad = 0;
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      if (slot_en !== (i <= 8)) bad++;
    end
    chk(bad == 0, "R2 slot window", bad, 0);

    // R6 console path, codec data ignored
    con_rx = 1'b1;
    drive_frame(8'h00, 1'b0);
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      con_rx = i[2];
      #1;
      if (host_rx !== con_rx) bad++;
    end
    chk(bad == 0, "R6 console passthrough", bad, 0);

    // stream mode
    @(negedge clk);
    con_rx = 1'b1;
    sel_voice = 1'b1;
    mon_en = 1'b1;
    drive_frame(8'h00, 1'b1);
    drive_frame(8'hFF, 1'b1);
    drive_frame(8'hA5, 1'b1);
    drive_frame(8'h5A, 1'b1);
    drive_frame(8'h01, 1'b1);
    drive_frame(8'h80, 1'b1);
    con_rx = 1'b0;
    for (int i = 0; i < 10; i++) drive_frame(8'(i*37 + 11), 1'b1);
    repeat (300) @(negedge clk);
    chk(expq.size() == 0, "R5 one char per frame", expq.size(), 0);
    mon_en = 1'b0;
    con_rx = 1'b1;

    // R7 stream -> console mid character
    do @(negedge clk); while (!fsync);
    bad = 0;
    for (int kk = 1; kk <= 255; kk++) begin
      @(negedge clk);
      if (kk <= 8) pcm_rx = 1'b0;
      if (kk == 60) sel_voice = 1'b0;
      #1;
      if (kk >= 61 && kk <= 170 && host_rx !== 1'b0) bad++;
      if (kk >= 172 && host_rx !== 1'b1) bad++;
    end
    chk(bad == 0, "R7 stream held until char end", bad, 0);

    // R7 console -> stream mid character
    do @(negedge clk); while (!fsync);
    bad = 0;
    for (int kk = 1; kk <= 171; kk++) begin
      @(negedge clk);
      if (kk <= 8) pcm_rx = 1'b0;
      if (kk == 60) sel_voice = 1'b1;
      #1;
      if (kk >= 61 && host_rx !== 1'b1) bad++;
    end
    chk(bad == 0, "R7 console held until char end", bad, 0);

    summary();
  end
endmodule